// File: doc/BRIEF.md
# Radix-2 Memory-Based FFT Stage

This block is one stage of a pipelined decimation-in-time FFT built from memory stages, in fixed point. The stage owns a double buffer split into real and imaginary halves. One bank is filled by the upstream stage through two write ports. The other bank is read by the stage's own butterfly datapath. When the upstream side pulses `frame_done`, the banks swap roles. The stage then walks the stored frame, one radix-2 butterfly per clock, for N/2 clocks. For each butterfly it reads two complex operands and fetches a twiddle factor from a ROM sized for its stage index. It emits both results on a paired write bus, at the same addresses the operands came from, so they can be written straight into the next stage's buffer.

A full transform of N points chains log2(N) of these stages, with the stage index l counting down from log2(N)-1 to 0. The frame enters stage log2(N)-1 with its samples written in bit-reversed address order, so that the last stage produces natural order. Operands, twiddles and results all use one width B with F fraction bits. There is no bit growth from stage to stage. The complex product is rounded to nearest, and the sums saturate instead of wrapping. The stage's `out_done` pulse is meant to drive the next stage's `frame_done`.

Top module: `r2_mem_stage`

## Requirements
- R1: After reset, `out_we`, `out_done`, `busy`, `ovf_flag` and `drop_err` are all 0.
- R2: A `frame_done` pulse seen while `busy` is 0 swaps the buffer banks, and `busy` is 1 from the next clock for exactly N/2 clocks. During that time the stage processes the frame that was written before the pulse.
- R3: For each butterfly, let a be the sample at address addr0, b the sample at addr1, and w the twiddle. Port 1 carries a + w·b at addr0 and port 2 carries a − w·b at addr1.
- R4: With span S = 2^(log2(N)−1−l), butterfly j (0 ≤ j < N/2) uses addr0 = (j div S)·2S + (j mod S), addr1 = addr0 + S, and twiddle index j mod S. On every cycle with `out_we` high, `out_addr2` = `out_addr1` + S.
- R5: Twiddle k has real part floor(cos(2πk/2S)·2^F + 0.5) and imaginary part floor(−sin(2πk/2S)·2^F + 0.5), each clamped to the signed B-bit range.
- R6: Each part of w·b is formed at full precision, then rounded to nearest: add 2^(F−1) and shift arithmetically right by F.
- R7: Each sum and difference saturates to the range −2^(B−1) … 2^(B−1)−1.
- R8: `ovf_flag` is set by any saturation in any result and stays set until reset.
- R9: The first result appears 2 clocks after the clock that accepts `frame_done`. Results appear on N/2 consecutive clocks, and `out_done` is high together with the last of them.
- R10: A `frame_done` seen while `busy` is 1 sets `drop_err`, which stays set until reset. Such a pulse does not swap the banks and has no effect on the frame in progress.
- R11: Writes made while a frame is being processed go to the load bank and do not disturb the results of the frame in progress. Each write port stores its real and imaginary data at its address when its enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_we1 | input | 1 | Write enable, load port 1 |
| in_addr1 | input | log2(N) | Address, load port 1 |
| in_re1 | input | B | Real data, load port 1 |
| in_im1 | input | B | Imaginary data, load port 1 |
| in_we2 | input | 1 | Write enable, load port 2 |
| in_addr2 | input | log2(N) | Address, load port 2 |
| in_re2 | input | B | Real data, load port 2 |
| in_im2 | input | B | Imaginary data, load port 2 |
| frame_done | input | 1 | Load bank complete; request a swap |
| out_we | output | 1 | Result pair valid |
| out_addr1 | output | log2(N) | Address of the sum result |
| out_re1 | output | B | Real part of the sum |
| out_im1 | output | B | Imaginary part of the sum |
| out_addr2 | output | log2(N) | Address of the difference result |
| out_re2 | output | B | Real part of the difference |
| out_im2 | output | B | Imaginary part of the difference |
| out_done | output | 1 | Last result pair of the frame |
| busy | output | 1 | Compute bank in use |
| ovf_flag | output | 1 | Sticky saturation flag |
| drop_err | output | 1 | Sticky dropped-frame flag |

## Verification
The assertions take two things for granted. First, `frame_done` is a single-clock pulse. Second, the upstream side writes only to the load bank and never rewrites the addresses of a frame after pulsing its completion. Under these assumptions, the address pairing and the flag behaviour follow from the stage alone. The stimulus holds each `frame_done` high for exactly one clock and fills all N addresses before each pulse. It overlaps loading with processing only after a swap has been accepted. The single deliberate violation is the early second pulse used to provoke a dropped frame.

// File: rtl/fft_stage_pkg.sv
package fft_stage_pkg;
  typedef enum logic {
    AG_IDLE = 1'b0,
    AG_RUN  = 1'b1
  } ag_state_e;
endpackage

// File: rtl/stage_addr_gen.sv
module stage_addr_gen
  import fft_stage_pkg::*;
#(
  parameter int N     = 256,
  parameter int STAGE = 0,
  parameter int TAW   = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  run,
  output logic                  last,
  output logic [$clog2(N)-1:0]  addr0,
  output logic [$clog2(N)-1:0]  addr1,
  output logic [TAW-1:0]        taddr
);
  localparam int AW   = $clog2(N);
  localparam int HALF = N / 2;
  localparam int CW   = $clog2(HALF);
  localparam int SB   = AW - 1 - STAGE;
  localparam int SPAN = 1 << SB;

  ag_state_e       st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [AW-1:0]   cnt_ext;

  assign run     = (st_q == AG_RUN);
  assign last    = run && (cnt_q == CW'(HALF - 1));
  assign cnt_ext = {1'b0, cnt_q};
  assign addr0   = ((cnt_ext >> SB) << (SB + 1)) | (cnt_ext & AW'(SPAN - 1));
  assign addr1   = addr0 | AW'(SPAN);
  assign taddr   = TAW'(cnt_ext & AW'(SPAN - 1));

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (st_q == AG_IDLE) begin
      if (start) begin
        st_n  = AG_RUN;
        cnt_n = '0;
      end
    end else if (last) begin
      st_n = AG_IDLE;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= AG_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  // R2
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run) |=> run);
  // R9
  last_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !run);
endmodule

// File: rtl/stage_twiddle_rom.sv
module stage_twiddle_rom #(
  parameter int B    = 8,
  parameter int F    = 6,
  parameter int TW_N = 128,
  parameter int TAW  = 7
) (
  input  logic                clk,
  input  logic                en,
  input  logic [TAW-1:0]      addr,
  output logic signed [B-1:0] w_re,
  output logic signed [B-1:0] w_im
);
  localparam int  DEPTH = 1 << TAW;
  localparam int  MAXV  = (1 << (B - 1)) - 1;
  localparam int  MINV  = -(1 << (B - 1));
  localparam real SC    = 2.0 ** F;

  logic signed [B-1:0] rom_re [DEPTH];
  logic signed [B-1:0] rom_im [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tw
    localparam int  KK  = k % TW_N;
    localparam real ANG = 6.283185307179586 * KK / (2.0 * TW_N);
    localparam real CR  = $floor($cos(ANG) * SC + 0.5);
    localparam real CI  = $floor(-$sin(ANG) * SC + 0.5);
    localparam int  QR  = (CR > MAXV) ? MAXV : (CR < MINV) ? MINV : int'(CR);
    localparam int  QI  = (CI > MAXV) ? MAXV : (CI < MINV) ? MINV : int'(CI);
    assign rom_re[k] = QR[B-1:0];
    assign rom_im[k] = QI[B-1:0];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      w_re <= rom_re[addr];
      w_im <= rom_im[addr];
    end
  end
endmodule

// File: rtl/stage_butterfly.sv
module stage_butterfly #(
  parameter int B = 8,
  parameter int F = 6
) (
  input  logic signed [B-1:0] a_re,
  input  logic signed [B-1:0] a_im,
  input  logic signed [B-1:0] b_re,
  input  logic signed [B-1:0] b_im,
  input  logic signed [B-1:0] w_re,
  input  logic signed [B-1:0] w_im,
  output logic signed [B-1:0] x_re,
  output logic signed [B-1:0] x_im,
  output logic signed [B-1:0] y_re,
  output logic signed [B-1:0] y_im,
  output logic                sat
);
  localparam int PW = 2 * B + 2;
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (B - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(1 << (B - 1));
  localparam logic signed [PW-1:0] RND  = PW'(1) << (F - 1);

  logic signed [PW-1:0] pr, pi, rr, ri;
  logic signed [PW-1:0] s_xr, s_xi, s_yr, s_yi;
  logic [3:0]           hit;

  function automatic logic signed [B-1:0] clip(input logic signed [PW-1:0] v);
    if (v > MAXV)      clip = MAXV[B-1:0];
    else if (v < MINV) clip = MINV[B-1:0];
    else               clip = v[B-1:0];
  endfunction

  always_comb begin
    pr   = PW'(b_re) * PW'(w_re) - PW'(b_im) * PW'(w_im);
    pi   = PW'(b_re) * PW'(w_im) + PW'(b_im) * PW'(w_re);
    rr   = (pr + RND) >>> F;
    ri   = (pi + RND) >>> F;
    s_xr = PW'(a_re) + rr;
    s_xi = PW'(a_im) + ri;
    s_yr = PW'(a_re) - rr;
    s_yi = PW'(a_im) - ri;
    hit  = {(s_xr > MAXV) || (s_xr < MINV), (s_xi > MAXV) || (s_xi < MINV),
            (s_yr > MAXV) || (s_yr < MINV), (s_yi > MAXV) || (s_yi < MINV)};
    sat  = |hit;
    x_re = clip(s_xr);
    x_im = clip(s_xi);
    y_re = clip(s_yr);
    y_im = clip(s_yi);
  end
endmodule

// File: rtl/r2_mem_stage.sv
module r2_mem_stage #(
  parameter int N     = 256,
  parameter int B     = 8,
  parameter int F     = 6,
  parameter int STAGE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_we1,
  input  logic [$clog2(N)-1:0] in_addr1,
  input  logic [B-1:0]         in_re1,
  input  logic [B-1:0]         in_im1,
  input  logic                 in_we2,
  input  logic [$clog2(N)-1:0] in_addr2,
  input  logic [B-1:0]         in_re2,
  input  logic [B-1:0]         in_im2,
  input  logic                 frame_done,
  output logic                 out_we,
  output logic [$clog2(N)-1:0] out_addr1,
  output logic [B-1:0]         out_re1,
  output logic [B-1:0]         out_im1,
  output logic [$clog2(N)-1:0] out_addr2,
  output logic [B-1:0]         out_re2,
  output logic [B-1:0]         out_im2,
  output logic                 out_done,
  output logic                 busy,
  output logic                 ovf_flag,
  output logic                 drop_err
);
  localparam int AW   = $clog2(N);
  localparam int SPAN = 1 << (AW - 1 - STAGE);
  localparam int TAW  = (SPAN > 1) ? $clog2(SPAN) : 1;

  logic [1:0]          rs_q;
  logic                rst_s;
  logic                run, last, accept;
  logic [AW-1:0]       a0, a1;
  logic [TAW-1:0]      ta;
  logic                sel_q, sel_n, ovf_q, ovf_n, drop_q, drop_n;
  logic                v1_q, last1_q, we_q, done_q;
  logic [AW-1:0]       a0_1q, a1_1q, oa1_q, oa2_q;
  logic signed [B-1:0] r1re, r1im, r2re, r2im, twre, twim;
  logic signed [B-1:0] bxr, bxi, byr, byi;
  logic [B-1:0]        o1re, o1im, o2re, o2im;
  logic                bsat;

  logic [B-1:0] mem_re [2][N];
  logic [B-1:0] mem_im [2][N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign accept = frame_done && !run;

  stage_addr_gen #(.N(N), .STAGE(STAGE), .TAW(TAW)) u_ag (
    .clk(clk), .rst_n(rst_s), .start(accept), .run(run), .last(last),
    .addr0(a0), .addr1(a1), .taddr(ta));

  stage_twiddle_rom #(.B(B), .F(F), .TW_N(SPAN), .TAW(TAW)) u_rom (
    .clk(clk), .en(run), .addr(ta), .w_re(twre), .w_im(twim));

  stage_butterfly #(.B(B), .F(F)) u_bf (
    .a_re(r1re), .a_im(r1im), .b_re(r2re), .b_im(r2im),
    .w_re(twre), .w_im(twim),
    .x_re(bxr), .x_im(bxi), .y_re(byr), .y_im(byi), .sat(bsat));

  // load bank: sel_q; compute bank: ~sel_q
  always_ff @(posedge clk) begin
    if (in_we1) begin
      mem_re[sel_q][in_addr1] <= in_re1;
      mem_im[sel_q][in_addr1] <= in_im1;
    end
    if (in_we2) begin
      mem_re[sel_q][in_addr2] <= in_re2;
      mem_im[sel_q][in_addr2] <= in_im2;
    end
  end

  always_ff @(posedge clk) begin
    if (run) begin
      r1re <= mem_re[~sel_q][a0];
      r1im <= mem_im[~sel_q][a0];
      r2re <= mem_re[~sel_q][a1];
      r2im <= mem_im[~sel_q][a1];
    end
  end

  always_ff @(posedge clk) begin
    if (v1_q) begin
      o1re <= bxr;
      o1im <= bxi;
      o2re <= byr;
      o2im <= byi;
    end
  end

  always_comb begin
    sel_n  = sel_q ^ accept;
    drop_n = drop_q | (frame_done & run);
    ovf_n  = ovf_q | (v1_q & bsat);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sel_q   <= 1'b0;
      drop_q  <= 1'b0;
      ovf_q   <= 1'b0;
      v1_q    <= 1'b0;
      last1_q <= 1'b0;
      a0_1q   <= '0;
      a1_1q   <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      oa1_q   <= '0;
      oa2_q   <= '0;
    end else begin
      sel_q   <= sel_n;
      drop_q  <= drop_n;
      ovf_q   <= ovf_n;
      v1_q    <= run;
      last1_q <= last;
      a0_1q   <= a0;
      a1_1q   <= a1;
      we_q    <= v1_q;
      done_q  <= last1_q;
      oa1_q   <= a0_1q;
      oa2_q   <= a1_1q;
    end
  end

  assign out_we    = we_q;
  assign out_done  = done_q;
  assign out_addr1 = oa1_q;
  assign out_addr2 = oa2_q;
  assign out_re1   = o1re;
  assign out_im1   = o1im;
  assign out_re2   = o2re;
  assign out_im2   = o2im;
  assign busy      = run;
  assign ovf_flag  = ovf_q;
  assign drop_err  = drop_q;

  // R4
  pair_span_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_we |-> (out_addr2 == out_addr1 + AW'(SPAN)));
  // R9
  done_with_we_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_done |-> out_we);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ovf_flag |=> ovf_flag);
  // R10
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
    drop_err |=> drop_err);
  // R10
  drop_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (frame_done && busy) |=> (drop_err && $stable(sel_q)));
endmodule

// File: tb/r2_mem_stage_test.sv
module r2_mem_stage_test;
  localparam int N = 16, B = 8, F = 6, STAGE = 1, S = 4, HALF = 8, AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_we1, in_we2, frame_done;
  logic [AW-1:0] in_addr1, in_addr2, out_addr1, out_addr2;
  logic [B-1:0] in_re1, in_im1, in_re2, in_im2;
  logic [B-1:0] out_re1, out_im1, out_re2, out_im2;
  logic out_we, out_done, busy, ovf_flag, drop_err;

  always #4 clk = ~clk;

  r2_mem_stage #(.N(N), .B(B), .F(F), .STAGE(STAGE)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_we1(in_we1), .in_addr1(in_addr1), .in_re1(in_re1), .in_im1(in_im1),
    .in_we2(in_we2), .in_addr2(in_addr2), .in_re2(in_re2), .in_im2(in_im2),
    .frame_done(frame_done), .out_we(out_we),
    .out_addr1(out_addr1), .out_re1(out_re1), .out_im1(out_im1),
    .out_addr2(out_addr2), .out_re2(out_re2), .out_im2(out_im2),
    .out_done(out_done), .busy(busy), .ovf_flag(ovf_flag), .drop_err(drop_err));

  // pattern table: {kind, amplitude}; kind 0 impulse, 1 constant, 2 ramp, 3 alternating
  localparam int TBL [5][2] = '{'{0, 40}, '{1, 20}, '{2, 3}, '{3, 25}, '{1, 127}};

  int checks = 0, errors = 0;
  bit fin = 0;
  int xr [N], xi [N], er [N], ei [N], gr [N], gi [N];
  bit ovf_model = 0;
  int first_cyc, n_we;
  bit saw_done;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int qtw(input real v);
    int q;
    q = int'($floor(v * 64.0 + 0.5));
    if (q > 127) q = 127;
    if (q < -128) q = -128;
    return q;
  endfunction

  function automatic int clampb(input int v, inout bit s);
    if (v > 127)  begin s = 1; return 127;  end
    if (v < -128) begin s = 1; return -128; end
    return v;
  endfunction

  task automatic fill(input int kind, input int amp);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: begin xr[i] = (i == 0) ? amp : 0; xi[i] = (i == 0) ? -amp : 0; end
        1: begin xr[i] = amp; xi[i] = -amp / 2; end
        2: begin xr[i] = i * amp; xi[i] = -(i * amp) / 2; end
        default: begin xr[i] = (i % 2) ? -amp : amp; xi[i] = (i % 3) ? amp : -amp; end
      endcase
    end
  endtask

  task automatic expect_frame();
    bit s = 0;
    for (int j = 0; j < HALF; j++) begin
      int k, a0, a1, wr, wi, pr, pi, rr, ri;
      real ang;
      k = j % S;
      a0 = (j / S) * 2 * S + k;
      a1 = a0 + S;
      ang = 6.283185307179586 * k / (2.0 * S);
      wr = qtw($cos(ang));
      wi = qtw(-$sin(ang));
      pr = xr[a1] * wr - xi[a1] * wi;
      pi = xr[a1] * wi + xi[a1] * wr;
      rr = (pr + 32) >>> 6;
      ri = (pi + 32) >>> 6;
      er[a0] = clampb(xr[a0] + rr, s);
      ei[a0] = clampb(xi[a0] + ri, s);
      er[a1] = clampb(xr[a0] - rr, s);
      ei[a1] = clampb(xi[a0] - ri, s);
    end
    ovf_model = ovf_model | s;
  endtask

  task automatic load();
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      in_we1 = 1; in_addr1 = AW'(2 * i);     in_re1 = B'(xr[2 * i]);     in_im1 = B'(xi[2 * i]);
      in_we2 = 1; in_addr2 = AW'(2 * i + 1); in_re2 = B'(xr[2 * i + 1]); in_im2 = B'(xi[2 * i + 1]);
    end
    @(negedge clk);
    in_we1 = 0; in_we2 = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
  endtask

  task automatic collect();
    int cyc = 0;
    first_cyc = -1; n_we = 0; saw_done = 0;
    for (int i = 0; i < N; i++) begin gr[i] = 999; gi[i] = 999; end
    while (!saw_done && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (out_we) begin
        if (first_cyc < 0) first_cyc = cyc;
        n_we++;
        gr[out_addr1] = int'($signed(out_re1)); gi[out_addr1] = int'($signed(out_im1));
        gr[out_addr2] = int'($signed(out_re2)); gi[out_addr2] = int'($signed(out_im2));
        if (out_addr2 != out_addr1 + AW'(S))
          chk(0, "R4 pair spacing", int'(out_addr2), int'(out_addr1) + S);
      end
      if (out_done) saw_done = 1;
    end
  endtask

  task automatic check_frame(input string tag);
    for (int i = 0; i < N; i++) begin
      chk(gr[i] == er[i], {tag, " re R3 R5 R6 R7"}, gr[i], er[i]);
      chk(gi[i] == ei[i], {tag, " im R3 R5 R6 R7"}, gi[i], ei[i]);
    end
    chk(first_cyc == 2, {tag, " R9 latency"}, first_cyc, 2);
    chk(n_we == HALF, {tag, " R9 result count"}, n_we, HALF);
    chk(saw_done, {tag, " R9 out_done"}, int'(saw_done), 1);
  endtask

  initial begin
    rst_n = 0; in_we1 = 0; in_we2 = 0; frame_done = 0;
    in_addr1 = '0; in_addr2 = '0; in_re1 = '0; in_im1 = '0; in_re2 = '0; in_im2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk(!out_we && !out_done && !busy, "R1 outputs idle", int'({out_we, out_done, busy}), 0);
    chk(!ovf_flag && !drop_err, "R1 flags clear", int'({ovf_flag, drop_err}), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int t = 0; t < 5; t++) begin
      fill(TBL[t][0], TBL[t][1]);
      expect_frame();
      load();
      pulse_done();
      chk(busy, "R2 busy after accept", int'(busy), 1);
      collect();
      check_frame($sformatf("table%0d", t));
      chk(ovf_flag == ovf_model, "R8 ovf flag", int'(ovf_flag), int'(ovf_model));
      chk(!busy, "R2 busy ends", int'(busy), 0);
    end

    // R11 overlap: load next frame while current one is processed
    fill(2, 2);
    expect_frame();
    load();
    pulse_done();
    fill(3, 11);
    fork
      collect();
      load();
    join
    check_frame("R11 current frame");
    chk(ovf_flag, "R8 ovf sticky", int'(ovf_flag), 1);
    expect_frame();
    pulse_done();
    collect();
    check_frame("R11 next frame");

    // R10 dropped frame_done while busy
    chk(!drop_err, "R10 no drop yet", int'(drop_err), 0);
    fill(0, 60);
    expect_frame();
    load();
    pulse_done();
    fork
      collect();
      begin
        frame_done = 1;
        @(negedge clk);
        frame_done = 0;
      end
    join
    check_frame("R10 frame in progress");
    chk(drop_err, "R10 drop flag", int'(drop_err), 1);
    repeat (3) @(negedge clk);
    chk(!busy, "R10 no restart from drop", int'(busy), 0);
    fill(1, 9);
    expect_frame();
    load();
    pulse_done();
    collect();
    check_frame("R10 after drop");
    chk(drop_err, "R10 drop sticky", int'(drop_err), 1);

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule